// File: doc/BRIEF.md
# Alignment-Driven Beat Splitter

This block turns a span of bytes, given as a start address and a byte count, into a series of bus beats for an incrementing transfer whose beat size is chosen automatically. For each beat it picks the widest power-of-two size that meets three limits:

- the current address is a multiple of that size;
- the size does not exceed the bytes still to send;
- the size is no wider than the data interface.

A span that starts off alignment therefore ramps up through byte, halfword and word beats, then narrows again as the tail runs out. With a 32-bit interface, 8 bytes from address 0x1 give a byte beat at 0x1, a halfword at 0x2, a word at 0x4 and a byte at 0x8.

Each beat is offered with a valid/ready handshake. A burst-permitted flag tells a downstream bus engine when a run of four full-width beats may be grouped. The interface width is a parameter, either 4 or 8 bytes. The block moves no data.

Top module: `beat_splitter`

## Requirements
- R1: After reset `beat_valid` and `done` are low.
- R2: While `beat_valid` is high, `beat_size` encodes the beat as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. It is the largest size whose byte count divides the current address, does not exceed the remaining count, and does not exceed `BUS_BYTES`.
- R3: The first beat's address equals `start_addr`. Each beat accepted (`beat_valid` and `beat_ready` high at a clock edge) advances the address by the beat's byte count and reduces the remaining count by the same amount.
- R4: While `beat_valid` is high and `beat_ready` is low, the offered address and size are held unchanged.
- R5: `done` is high for exactly the one cycle after the edge that accepts the last beat. `beat_valid` is low in that cycle.
- R6: A start with a byte count of zero issues no beat and raises `done` for the one cycle after the start edge.
- R7: `burst_ok` is high exactly when `beat_valid` is high, the address is a multiple of `BUS_BYTES`, and at least `4*BUS_BYTES` bytes remain.
- R8: `start` is accepted only while `beat_valid` is low. A start during a transfer changes neither the beats offered nor the timing of `done`.
- R9: With `BUS_BYTES` of 4 or 8, a span whose start address and length are both multiples of `BUS_BYTES` is sent entirely as full-width beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load a new span (taken only when idle) |
| start_addr | input | ADDR_W | First byte address of the span |
| byte_count | input | LEN_W | Span length in bytes |
| beat_ready | input | 1 | Consumer accepts the offered beat |
| beat_valid | output | 1 | A beat is offered |
| beat_addr | output | ADDR_W | Address of the offered beat |
| beat_size | output | 2 | log2 of the beat's byte count |
| burst_ok | output | 1 | A four-beat full-width burst may start here |
| done | output | 1 | One-cycle pulse when the span has finished |

## Verification
A start seen at one edge produces its first beat, or for a zero length its `done` pulse, in the cycle right after that edge. Each accepted beat is replaced by the next one after one edge. `done` follows the accepting edge of the last beat by one cycle.

The bench drives its inputs just after each rising edge and checks every output at the falling edge. A reference model predicts, at each falling edge, the state the next rising edge will produce, so every comparison lands in the exact cycle its result is due. Spans are swept across every start offset within 16 bytes and every length from 0 to 40, on both interface widths at once, with random and steady `beat_ready` patterns and with stray starts mid-transfer.

// File: rtl/beat_splitter.sv
module beat_splitter #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BUS_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  byte_count,
  input  logic              beat_ready,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [1:0]        beat_size,
  output logic              burst_ok,
  output logic              done
);
  localparam int MAXS = $clog2(BUS_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              done_q;
  logic [1:0]        sz;
  logic [LEN_W-1:0]  step;
  logic              fire;

  always_comb begin
    sz = 2'd0;
    for (int s = 1; s <= MAXS; s++)
      if (((addr_q & ADDR_W'((1 << s) - 1)) == '0) &&
          ({1'b0, rem_q} >= (LEN_W+1)'(1 << s)))
        sz = 2'(s);
  end

  assign step       = LEN_W'(1) << sz;
  assign beat_valid = rem_q != '0;
  assign beat_addr  = addr_q;
  assign beat_size  = sz;
  assign fire       = beat_valid && beat_ready;
  assign done       = done_q;
  assign burst_ok   = beat_valid &&
                      ((addr_q & ADDR_W'(BUS_BYTES - 1)) == '0) &&
                      ({1'b0, rem_q} >= (LEN_W+1)'(4 * BUS_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fire) begin
        addr_q <= addr_q + ADDR_W'(step);
        rem_q  <= rem_q - step;
        if (rem_q == step) done_q <= 1'b1;
      end else if (start && !beat_valid) begin
        addr_q <= start_addr;
        rem_q  <= byte_count;
        done_q <= byte_count == '0;
      end
    end
  end
endmodule

// File: rtl/beat_splitter_props.sv
module beat_splitter_props #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BUS_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [1:0]        beat_size,
  input logic              burst_ok,
  input logic              done
);
  localparam int MAXS = $clog2(BUS_BYTES);

  a_r2_size_cap: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> int'(beat_size) <= MAXS);

  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> ((beat_addr & ((ADDR_W'(1) << beat_size) - ADDR_W'(1))) == '0));

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready |=>
      !beat_valid || beat_addr == $past(beat_addr) + (ADDR_W'(1) << $past(beat_size)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=>
      beat_valid && $stable(beat_addr) && $stable(beat_size));

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !beat_valid);

  a_r7_burst_full: assert property (@(posedge clk) disable iff (!rst_n)
    burst_ok |-> beat_valid && int'(beat_size) == MAXS &&
                 ((beat_addr & ADDR_W'(BUS_BYTES - 1)) == '0));
endmodule

bind beat_splitter beat_splitter_props #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)
) u_props (
  .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_ready(beat_ready),
  .beat_addr(beat_addr), .beat_size(beat_size), .burst_ok(burst_ok), .done(done)
);

// File: tb/beat_splitter_test.sv
module beat_ref #(
  parameter int BB = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] sa,
  input  logic [7:0]  bc,
  input  logic        ready,
  input  logic        valid,
  input  logic [31:0] addr,
  input  logic [1:0]  size,
  input  logic        burst,
  input  logic        done,
  output int          chk,
  output int          err,
  output logic        idle
);
  localparam int MAXS = $clog2(BB);
  int ea, er, sz;
  bit eb, ed, zl, al, stalled, ign;

  initial begin
    chk = 0; err = 0; eb = 0; ed = 0; zl = 0; al = 0; stalled = 0; ign = 0;
  end
  assign idle = !eb && !ed;

  function automatic int exp_sz(int a, int r);
    int s = 0;
    for (int k = 1; k <= MAXS; k++)
      if (a % (1 << k) == 0 && r >= (1 << k)) s = k;
    return s;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    chk++;
    if (!ok) begin
      err++;
      $display("FAIL %s bus=%0dB actual=%0h expected=%0h", tag, BB, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      eb = 0; ed = 0; stalled = 0; ign = 0;
      check(valid == 1'b0, "R1 valid", int'(valid), 0);
      check(done == 1'b0, "R1 done", int'(done), 0);
    end else begin
      check(valid == eb, ign ? "R8 valid" : "R5 valid", int'(valid), int'(eb));
      check(done == ed, zl ? "R6 done" : (ign ? "R8 done" : "R5 done"), int'(done), int'(ed));
      if (eb) begin
        sz = exp_sz(ea, er);
        check(addr == 32'(ea), stalled ? "R4 addr" : (ign ? "R8 addr" : "R3 addr"), int'(addr), ea);
        check(int'(size) == sz, stalled ? "R4 size" : "R2 size", int'(size), sz);
        if (al) check(int'(size) == MAXS, "R9 full width", int'(size), MAXS);
      end
      check(burst == (eb && ea % BB == 0 && er >= 4 * BB), "R7 burst", int'(burst),
            int'(eb && ea % BB == 0 && er >= 4 * BB));
      // predict the state after the coming rising edge
      ed = 0;
      stalled = eb && !ready;
      if (eb && ready) begin
        ea += (1 << sz);
        er -= (1 << sz);
        if (er == 0) begin eb = 0; ed = 1; end
      end else if (!eb && start) begin
        ea = int'(sa); er = int'(bc);
        eb = bc != 0; ed = bc == 0; zl = bc == 0;
        al = (int'(sa) % BB == 0) && (int'(bc) % BB == 0);
        ign = 0;
      end
      if (eb && start) ign = 1;
    end
  end
endmodule

module beat_splitter_test;
  logic        clk = 0, rst_n = 0, start = 0, ready = 0;
  logic [31:0] sa = '0;
  logic [7:0]  bc = '0;
  logic        v4, b4, d4, v8, b8, d8;
  logic [31:0] a4, a8;
  logic [1:0]  s4, s8;
  int          c4, e4, c8, e8, own_chk = 0, own_err = 0;
  logic        i4, i8;

  always #10 clk = ~clk;

  beat_splitter #(.ADDR_W(32), .LEN_W(8), .BUS_BYTES(4)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(sa), .byte_count(bc),
    .beat_ready(ready), .beat_valid(v4), .beat_addr(a4), .beat_size(s4),
    .burst_ok(b4), .done(d4));
  beat_splitter #(.ADDR_W(32), .LEN_W(8), .BUS_BYTES(8)) uut64 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(sa), .byte_count(bc),
    .beat_ready(ready), .beat_valid(v8), .beat_addr(a8), .beat_size(s8),
    .burst_ok(b8), .done(d8));

  beat_ref #(.BB(4)) m4 (.clk(clk), .rst_n(rst_n), .start(start), .sa(sa), .bc(bc),
    .ready(ready), .valid(v4), .addr(a4), .size(s4), .burst(b4), .done(d4),
    .chk(c4), .err(e4), .idle(i4));
  beat_ref #(.BB(8)) m8 (.clk(clk), .rst_n(rst_n), .start(start), .sa(sa), .bc(bc),
    .ready(ready), .valid(v8), .addr(a8), .size(s8), .burst(b8), .done(d8),
    .chk(c8), .err(e8), .idle(i8));

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors",
             c4 + c8 + own_chk, e4 + e8 + own_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    own_chk++; own_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic tick();
    @(posedge clk); #3;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    for (int off = 0; off < 16; off++) begin
      for (int len = 0; len <= 40; len++) begin
        sa = 32'h1000 + 32'(off); bc = 8'(len); start = 1;
        ready = (len % 3 == 0) ? 1'b1 : 1'($urandom % 2);
        tick();
        start = 0;
        for (int cyc = 0; cyc < 400 && !(i4 && i8); cyc++) begin
          ready = (len % 3 == 0) ? 1'b1 : 1'($urandom % 2);
          if (cyc == 1 && len % 2 == 1) begin  // stray start mid-transfer (R8)
            start = 1; sa = 32'h2000; bc = 8'd3;
          end else start = 0;
          tick();
        end
        start = 0;
        own_chk++;
        if (!(i4 && i8)) begin
          own_err++;
          $display("FAIL R5 span off=%0d len=%0d actual=busy expected=idle", off, len);
        end
      end
    end
    repeat (3) tick();
    summary();
  end
endmodule